// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves that a 2-bit mode field either runs apart or chains into one 16-bit count. A shared 8-bit programmable prescaler produces the timer tick from the system clock. A synchronized external event input provides the counting source for the event-counter functions. Each half wraps to zero when it reaches its match value and raises its own interrupt flag.

Two capture strobes, one for each half, copy the live count into capture registers. Software reads those registers back over a small register bus. In the split modes each strobe latches only its own half. In the 16-bit modes either strobe latches the whole count. Writing the mode register restarts both the count and the prescaler.

Register map (write and read, 3-bit address): 0 mode (bits 1:0), 1 prescaler value P, 2 low match, 3 high match, 4 flags (read {irq_hi,irq_lo} in bits 1:0; writing a 1 clears the matching flag), 5 low capture, 6 high capture, 7 live low count (read only).

Top module: `cap_timer16`

## Requirements
- R1: While reset is asserted, every readable address returns 0, the mode is 0 and both interrupt flags are low.
- R2: The prescaler counts system clocks from 0 to P and issues one timer tick when it holds P, so a timer advances once every P+1 clocks.
- R3: Mode 0 runs two independent 8-bit timers, both advanced by the tick. When a half advances while it equals its match register, it goes to 0 and sets its flag (irq_lo for the low half, irq_hi for the high half).
- R4: Mode 1 advances the low half on the tick and the high half on event strobes, with the same per-half match, wrap and flag rules as R3.
- R5: Mode 2 is a 16-bit timer on the tick that wraps to 0 when {high match, low match} is reached and then sets only irq_hi. irq_lo is never set in modes 2 and 3.
- R6: Mode 3 is a 16-bit counter of event strobes, with the 16-bit match rule of R5.
- R7: The event and capture inputs pass through a two-flop synchronizer and a rising-edge detector. A high level lasting one clock or more counts exactly once, and its effect appears on the third clock edge after the input rises.
- R8: In modes 0 and 1 the low capture strobe copies the low count into the low capture register, and the high strobe copies the high count into the high capture register.
- R9: In modes 2 and 3 either capture strobe copies the full 16-bit count into both capture registers.
- R10: A write to address 0 loads the new mode and clears both count halves and the prescaler on the same edge.
- R11: Writing 1 to bit 0 or bit 1 of address 4 clears irq_lo or irq_hi. A flag set on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| event_in | input | 1 | External event input, asynchronous |
| cap_lo_in | input | 1 | Low-half capture strobe input, asynchronous |
| cap_hi_in | input | 1 | High-half capture strobe input, asynchronous |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or 16-bit match flag |

## Verification
The embedded assertions check several rules on every cycle: strobes from the synchronizer last a single cycle, the prescaler restarts after each tick, a mode write leaves both halves at zero, captures copy the count held before the strobe (by half or as the full 16 bits depending on mode), and irq_lo never rises while a 16-bit mode is active. The bench model covers what only whole sequences can show. This includes wrap periods that depend on P and on the match values, the three-edge synchronizer latency, one count for a long input level, and the set-over-clear priority of the flags. The model also checks that captures and flags follow the mode changes made in the middle of a run.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [1:0] {
    MD_DUAL     = 2'd0,
    MD_TMR_EVT  = 2'd1,
    MD_WIDE_TMR = 2'd2,
    MD_WIDE_EVT = 2'd3
  } ct_mode_e;

  function automatic logic mode_is_wide(input ct_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] rise_pulse
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [2:0] stg_q, stg_n;

    always_comb stg_n = {stg_q[1:0], async_in[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_n;
    end

    assign rise_pulse[i] = stg_q[1] & ~stg_q[2];

    // R7: one clean strobe per rising level
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse[i] |=> !rise_pulse[i]);
  end
endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] limit,
  output logic          tick
);
  logic [PW-1:0] pcnt_q, pcnt_n;

  assign tick = (pcnt_q == limit);

  always_comb begin
    if (clr || tick) pcnt_n = '0;
    else             pcnt_n = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end

  // R2: after a tick the divider restarts from zero
  a_r2_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt_q == '0));
  // R10: a mode write restarts the divider
  a_r10_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt_q == '0));
endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ct_mode_e      mode,
  input  logic          clr,
  input  logic          tick,
  input  logic          evt,
  input  logic          cap_lo_p,
  input  logic          cap_hi_p,
  input  logic [HW-1:0] match_lo,
  input  logic [HW-1:0] match_hi,
  input  logic [1:0]    flag_clr,
  output logic [HW-1:0] cnt_lo,
  output logic [HW-1:0] cnt_hi,
  output logic [HW-1:0] cap_lo,
  output logic [HW-1:0] cap_hi,
  output logic          flag_lo,
  output logic          flag_hi
);
  localparam int FW = 2 * HW;

  logic [HW-1:0] lo_n, hi_n, caplo_n, caphi_n;
  logic [FW-1:0] wide_inc;
  logic          set_lo, set_hi, adv_hi, adv_wide, wide;
  logic          flo_n, fhi_n, cap_en;

  assign wide     = mode_is_wide(mode);
  assign adv_hi   = (mode == MD_DUAL) ? tick : evt;
  assign adv_wide = (mode == MD_WIDE_TMR) ? tick : evt;
  assign wide_inc = {cnt_hi, cnt_lo} + 1'b1;

  always_comb begin
    lo_n   = cnt_lo;
    hi_n   = cnt_hi;
    set_lo = 1'b0;
    set_hi = 1'b0;
    if (clr) begin
      lo_n = '0;
      hi_n = '0;
    end else if (!wide) begin
      if (tick) begin
        if (cnt_lo == match_lo) begin lo_n = '0; set_lo = 1'b1; end
        else                          lo_n = cnt_lo + 1'b1;
      end
      if (adv_hi) begin
        if (cnt_hi == match_hi) begin hi_n = '0; set_hi = 1'b1; end
        else                          hi_n = cnt_hi + 1'b1;
      end
    end else if (adv_wide) begin
      if ({cnt_hi, cnt_lo} == {match_hi, match_lo}) begin
        lo_n = '0; hi_n = '0; set_hi = 1'b1;
      end else begin
        {hi_n, lo_n} = wide_inc;
      end
    end
  end

  always_comb begin
    caplo_n = cap_lo;
    caphi_n = cap_hi;
    cap_en  = cap_lo_p | cap_hi_p;
    if (wide) begin
      if (cap_en) begin caplo_n = cnt_lo; caphi_n = cnt_hi; end
    end else begin
      if (cap_lo_p) caplo_n = cnt_lo;
      if (cap_hi_p) caphi_n = cnt_hi;
    end
    flo_n = set_lo | (flag_lo & ~flag_clr[0]);
    fhi_n = set_hi | (flag_hi & ~flag_clr[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo  <= '0;
      cnt_hi  <= '0;
      cap_lo  <= '0;
      cap_hi  <= '0;
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      cnt_lo  <= lo_n;
      cnt_hi  <= hi_n;
      cap_lo  <= caplo_n;
      cap_hi  <= caphi_n;
      flag_lo <= flo_n;
      flag_hi <= fhi_n;
    end
  end

  // R5: low flag never rises from a 16-bit mode
  a_r5_lo_quiet_wide: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_lo) |-> !$past(wide));
  // R10: mode write leaves both halves at zero
  a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_lo == '0 && cnt_hi == '0));
  // R8: split-mode low capture takes the pre-edge low count
  a_r8_split_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lo_p && !wide) |=> (cap_lo == $past(cnt_lo)));
  // R9: wide capture takes the full pre-edge count
  a_r9_wide_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_lo_p || cap_hi_p) && wide) |=>
      ({cap_hi, cap_lo} == {$past(cnt_hi), $past(cnt_lo)}));
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import ct_pkg::*;
#(
  parameter int HW = 8,
  parameter int PW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [HW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [HW-1:0] rd_data,
  input  logic          event_in,
  input  logic          cap_lo_in,
  input  logic          cap_hi_in,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_PRE  = AW'(1);
  localparam logic [AW-1:0] A_MLO  = AW'(2);
  localparam logic [AW-1:0] A_MHI  = AW'(3);
  localparam logic [AW-1:0] A_FLG  = AW'(4);
  localparam logic [AW-1:0] A_CLO  = AW'(5);
  localparam logic [AW-1:0] A_CHI  = AW'(6);
  localparam logic [AW-1:0] A_CNT  = AW'(7);

  ct_mode_e      mode_q, mode_n;
  logic [PW-1:0] pre_q, pre_n;
  logic [HW-1:0] mlo_q, mlo_n, mhi_q, mhi_n;
  logic          wr_mode, wr_pre, wr_mlo, wr_mhi, wr_flg, tick;
  logic [2:0]    strobes;
  logic [1:0]    flag_clr;
  logic [HW-1:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
  logic          wr_data_unused;

  assign wr_data_unused = ^wr_data[HW-1:2];
  assign wr_mode  = wr_en && (wr_addr == A_MODE);
  assign wr_pre   = wr_en && (wr_addr == A_PRE);
  assign wr_mlo   = wr_en && (wr_addr == A_MLO);
  assign wr_mhi   = wr_en && (wr_addr == A_MHI);
  assign wr_flg   = wr_en && (wr_addr == A_FLG);
  assign flag_clr = wr_flg ? wr_data[1:0] : 2'b00;

  always_comb begin
    mode_n = wr_mode ? ct_mode_e'(wr_data[1:0]) : mode_q;
    pre_n  = wr_pre  ? PW'(wr_data) : pre_q;
    mlo_n  = wr_mlo  ? wr_data : mlo_q;
    mhi_n  = wr_mhi  ? wr_data : mhi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_DUAL;
      pre_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
    end else begin
      mode_q <= mode_n;
      pre_q  <= pre_n;
      mlo_q  <= mlo_n;
      mhi_q  <= mhi_n;
    end
  end

  ct_edge_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({cap_hi_in, cap_lo_in, event_in}),
    .rise_pulse(strobes)
  );

  ct_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_mode), .limit(pre_q), .tick(tick)
  );

  ct_core #(.HW(HW)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .clr(wr_mode), .tick(tick),
    .evt(strobes[0]), .cap_lo_p(strobes[1]), .cap_hi_p(strobes[2]),
    .match_lo(mlo_q), .match_hi(mhi_q), .flag_clr(flag_clr),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .flag_lo(irq_lo), .flag_hi(irq_hi)
  );

  always_comb begin
    unique case (rd_addr)
      A_MODE:  rd_data = HW'(mode_q);
      A_PRE:   rd_data = HW'(pre_q);
      A_MLO:   rd_data = mlo_q;
      A_MHI:   rd_data = mhi_q;
      A_FLG:   rd_data = HW'({irq_hi, irq_lo});
      A_CLO:   rd_data = cap_lo;
      A_CHI:   rd_data = cap_hi;
      default: rd_data = cnt_lo;
    endcase
  end

  // R11: a clear with no concurrent match drops the flag
  a_r11_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[1] && !$past(wr_mode) && mode_q == MD_WIDE_EVT && !strobes[0]) |=> !irq_hi);
endmodule

// File: tb/cap_timer16_test.sv
`timescale 1ns/1ps
module cap_timer16_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       event_in, cap_lo_in, cap_hi_in;
  logic       irq_lo, irq_hi;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cap_timer16 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .event_in(event_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural reference
  logic [7:0] m_pc, m_pr, m_ml, m_mh, m_lo, m_hi, m_cl, m_ch;
  logic [1:0] m_mode;
  logic       m_fl, m_fh;
  logic [2:0] h_ev, h_cl, h_ch;
  logic       ep, clp, chp, tk, s_l, s_h, adv;
  logic [15:0] w;

  function automatic logic [7:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return {6'd0, m_mode};
      3'd1: return m_pr;
      3'd2: return m_ml;
      3'd3: return m_mh;
      3'd4: return {6'd0, m_fh, m_fl};
      3'd5: return m_cl;
      3'd6: return m_ch;
      default: return m_lo;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_pr = 0; m_ml = 0; m_mh = 0; m_lo = 0; m_hi = 0;
      m_cl = 0; m_ch = 0; m_mode = 0; m_fl = 0; m_fh = 0;
      h_ev = 0; h_cl = 0; h_ch = 0;
    end else begin
      ep  = h_ev[1] & ~h_ev[2];
      clp = h_cl[1] & ~h_cl[2];
      chp = h_ch[1] & ~h_ch[2];
      h_ev = {h_ev[1:0], event_in};
      h_cl = {h_cl[1:0], cap_lo_in};
      h_ch = {h_ch[1:0], cap_hi_in};
      tk = (m_pc == m_pr); s_l = 0; s_h = 0;
      if (!m_mode[1]) begin
        if (clp) m_cl = m_lo;
        if (chp) m_ch = m_hi;
      end else if (clp || chp) begin
        m_cl = m_lo; m_ch = m_hi;
      end
      if (wr_en && wr_addr == 3'd0) begin
        m_mode = wr_data[1:0]; m_pc = 0; m_lo = 0; m_hi = 0;
      end else begin
        m_pc = tk ? 8'd0 : m_pc + 8'd1;
        if (!m_mode[1]) begin
          if (tk) begin
            if (m_lo == m_ml) begin m_lo = 0; s_l = 1; end else m_lo = m_lo + 8'd1;
          end
          adv = (m_mode == 2'd0) ? tk : ep;
          if (adv) begin
            if (m_hi == m_mh) begin m_hi = 0; s_h = 1; end else m_hi = m_hi + 8'd1;
          end
        end else begin
          adv = (m_mode == 2'd2) ? tk : ep;
          if (adv) begin
            if ({m_hi, m_lo} == {m_mh, m_ml}) begin m_hi = 0; m_lo = 0; s_h = 1; end
            else begin w = {m_hi, m_lo} + 16'd1; m_hi = w[15:8]; m_lo = w[7:0]; end
          end
        end
      end
      m_fl = s_l | (m_fl & !(wr_en && wr_addr == 3'd4 && wr_data[0]));
      m_fh = s_h | (m_fh & !(wr_en && wr_addr == 3'd4 && wr_data[1]));
      if (wr_en && wr_addr == 3'd1) m_pr = wr_data;
      if (wr_en && wr_addr == 3'd2) m_ml = wr_data;
      if (wr_en && wr_addr == 3'd3) m_mh = wr_data;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, rd_data, mread(rd_addr));
      chk(cur_req, {irq_hi, irq_lo}, {m_fh, m_fl});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); #1 wr_en = 0;
  endtask

  task automatic evt_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      event_in = 1; idle(1); event_in = 0; idle(1);
    end
  endtask

  task automatic strobe_hi();
    cap_hi_in = 1; idle(1); cap_hi_in = 0; idle(4);
  endtask

  task automatic strobe_lo();
    cap_lo_in = 1; idle(1); cap_lo_in = 0; idle(4);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 3'd7;
    event_in = 0; cap_lo_in = 0; cap_hi_in = 0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd_addr = a[2:0]; #1;
      chk("R1", rd_data, 0);
    end
    chk("R1", {irq_hi, irq_lo}, 0);
    rd_addr = 3'd7; #1 rst_n = 1;
    idle(3);

    cur_req = "R2";
    wr(3'd1, 8'd2); wr(3'd2, 8'd3); wr(3'd3, 8'd5);
    cur_req = "R3";
    wr(3'd0, 8'd0);
    idle(40);
    wr(3'd4, 8'd3); idle(30);
    cur_req = "R2";
    wr(3'd1, 8'd0); idle(20);
    wr(3'd1, 8'd5); idle(30);

    cur_req = "R8";
    wr(3'd1, 8'd1);
    rd_addr = 3'd5; strobe_lo(); idle(7);
    rd_addr = 3'd6; strobe_hi(); idle(3);
    cap_lo_in = 1; cap_hi_in = 1; idle(2); cap_lo_in = 0; cap_hi_in = 0; idle(5);

    cur_req = "R4";
    rd_addr = 3'd4;
    wr(3'd3, 8'd4); wr(3'd0, 8'd1);
    evt_pulses(12); idle(4);
    rd_addr = 3'd6; strobe_hi();

    cur_req = "R5";
    rd_addr = 3'd7;
    wr(3'd1, 8'd0); wr(3'd2, 8'h10); wr(3'd3, 8'h01);
    wr(3'd0, 8'd2); wr(3'd4, 8'd3);
    idle(600);
    rd_addr = 3'd4; idle(5); wr(3'd4, 8'd2);

    cur_req = "R10";
    rd_addr = 3'd7;
    idle(17);
    wr(3'd0, 8'd2);
    chk("R10", rd_data, 0);
    idle(3);

    cur_req = "R6";
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'd3);
    evt_pulses(5); idle(4);
    strobe_hi();
    rd_addr = 3'd5; #1 chk("R6", rd_data, 5);
    rd_addr = 3'd6; #1 chk("R9", rd_data, 0);

    cur_req = "R7";
    event_in = 1; idle(10); event_in = 0; idle(4);
    rd_addr = 3'd5; strobe_lo();
    chk("R7", rd_data, 6);

    cur_req = "R11";
    wr(3'd4, 8'd3);
    rd_addr = 3'd4; #1 chk("R11", rd_data, 0);
    chk("R11", {irq_hi, irq_lo}, 0);
    wr(3'd2, 8'd6); wr(3'd3, 8'd0);
    event_in = 1; idle(1); event_in = 0; idle(1);
    wr(3'd4, 8'd2); idle(3);
    chk("R11", irq_hi, 1);

    cur_req = "R9";
    wr(3'd1, 8'd3); wr(3'd3, 8'd2); wr(3'd0, 8'd2);
    idle(200);
    rd_addr = 3'd6; strobe_lo(); idle(50);
    rd_addr = 3'd5; strobe_hi(); idle(10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog (%s): got %0d cycles expected under %0d", cur_req, cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule